// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block chooses which clocks and clock sources are enabled for each of six operating modes: one active mode and five low-power levels. Software selects a mode by writing a 3-bit code. The block drives five enable outputs:

- the CPU clock,
- the auxiliary clock,
- the peripheral clock,
- the bias generator of the digitally controlled oscillator (DCO),
- the crystal oscillator.

The oscillators, clock dividers and source multiplexers sit outside the block. They only receive these enables.

When an interrupt request arrives in any low-power level, the controller saves the current mode in a one-entry register. It then forces the active pattern and holds it until a return strobe comes. On return it restores the saved level, unless the handler has discarded the saved level; in that case the device stays active. All enables come from flip-flops driven by a decoder that looks at the next state, so they switch together on one clock edge without glitches.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After a synchronous reset, `cur_mode` is 0 (active), every enable output is 1 and `in_service` is 0.
- R2: Outside service, a write with `mode_wdata` 0 selects active and codes 1 to 5 select low-power levels 0 to 4. `cur_mode` shows the code on the cycle after the write. Codes 6 and 7 leave `cur_mode` and the enables unchanged.
- R3: The enables {cpu, aux, per, dco, xtal} follow `cur_mode` as shown below. The enables change on the same edge as `cur_mode`.

  | `cur_mode` | Mode | cpu | aux | per | dco | xtal |
  |---|---|---|---|---|---|---|
  | 0 | active | 1 | 1 | 1 | 1 | 1 |
  | 1 | low-power level 0 | 0 | 1 | 1 | 1 | 1 |
  | 3 | low-power level 2 | 0 | 1 | 0 | 1 | 1 |
  | 4 | low-power level 3 | 0 | 1 | 0 | 0 | 1 |
  | 5 | low-power level 4 | 0 | 0 | 0 | 0 | 0 |

- R4: In code 2 (low-power level 1), the enables are cpu 0, aux 1 and per 1. `dco_gen_en` equals the `dco_drives_cpu` input of the previous cycle.
- R5: When `irq` is high outside service and `cur_mode` is not 0, the next cycle shows `in_service`=1, `cur_mode`=0 and all enables at 1. The previous code is kept as the saved level.
- R6: `irq` has no effect while `cur_mode` is 0 outside service, and has no effect while `in_service` is 1.
- R7: A `reti` pulse during service clears `in_service` on the next cycle and restores the saved code, together with its enable pattern.
- R8: If `saved_clr` is high during service, before or together with `reti`, the return goes to code 0 (active).
- R9: Mode writes are ignored while `in_service` is 1. `reti` and `saved_clr` are ignored outside service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Requested mode code |
| dco_drives_cpu | input | 1 | 1 when the DCO sources the CPU clock in active mode |
| irq | input | 1 | Pending interrupt request |
| reti | input | 1 | Return-from-interrupt strobe |
| saved_clr | input | 1 | Discard the saved mode during service |
| cur_mode | output | 3 | Current mode code |
| in_service | output | 1 | Woken by an interrupt and not yet returned |
| cpu_clk_en | output | 1 | CPU clock enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| dco_gen_en | output | 1 | DCO bias generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The properties assume that every input is synchronous to `clk` and holds steady for the whole cycle around a rising edge. They also assume that `reti` and `saved_clr` carry meaning only while in service. The stimulus drives all inputs on the falling edge and keeps each value for a full period. It mixes random writes (illegal codes included), interrupts, returns and clears with directed sequences, so the second assumption is tested against the design rather than relied on.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 6;

  typedef enum logic [MODE_W-1:0] {
    PM_ACTIVE = 3'd0,
    PM_LP0    = 3'd1,
    PM_LP1    = 3'd2,
    PM_LP2    = 3'd3,
    PM_LP3    = 3'd4,
    PM_LP4    = 3'd5
  } pmode_e;

  typedef struct packed {
    logic cpu;
    logic aux;
    logic per;
    logic dco;
    logic xtal;
  } clk_en_t;

  localparam clk_en_t EN_ALL_ON = '{cpu: 1'b1, aux: 1'b1, per: 1'b1, dco: 1'b1, xtal: 1'b1};

  function automatic logic code_legal(logic [MODE_W-1:0] code);
    return int'(code) < NUM_MODES;
  endfunction

  // Enable pattern per mode; dco_keep only matters for the first-but-one level
  function automatic clk_en_t mode_pattern(pmode_e m, logic dco_keep);
    clk_en_t e;
    e = EN_ALL_ON;
    unique case (m)
      PM_ACTIVE: e = EN_ALL_ON;
      PM_LP0:    e.cpu = 1'b0;
      PM_LP1: begin
        e.cpu = 1'b0;
        e.dco = dco_keep;
      end
      PM_LP2: begin
        e.cpu = 1'b0;
        e.per = 1'b0;
      end
      PM_LP3: begin
        e.cpu = 1'b0;
        e.per = 1'b0;
        e.dco = 1'b0;
      end
      PM_LP4: e = '0;
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
  import lpm_pkg::*;
#(
  parameter int CODE_W = MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [CODE_W-1:0] mode_wdata,
  input  logic              irq,
  input  logic              reti,
  input  logic              saved_clr,
  output pmode_e            mode_q,
  output pmode_e            mode_d,
  output logic              srv_q
);
  pmode_e saved_q, saved_d;
  logic   saved_vld_q, saved_vld_d;
  logic   srv_d;
  logic   wake;

  assign wake = !srv_q && irq && (mode_q != PM_ACTIVE);

  always_comb begin
    mode_d      = mode_q;
    saved_d     = saved_q;
    saved_vld_d = saved_vld_q;
    srv_d       = srv_q;
    if (srv_q) begin
      if (reti) begin
        mode_d      = (saved_vld_q && !saved_clr) ? saved_q : PM_ACTIVE;
        saved_vld_d = 1'b0;
        srv_d       = 1'b0;
      end else if (saved_clr) begin
        saved_vld_d = 1'b0;
      end
    end else if (wake) begin
      saved_d     = mode_q;
      saved_vld_d = 1'b1;
      srv_d       = 1'b1;
      mode_d      = PM_ACTIVE;
    end else if (mode_wr && code_legal(mode_wdata)) begin
      mode_d = pmode_e'(mode_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= PM_ACTIVE;
      saved_q     <= PM_ACTIVE;
      saved_vld_q <= 1'b0;
      srv_q       <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      saved_q     <= saved_d;
      saved_vld_q <= saved_vld_d;
      srv_q       <= srv_d;
    end
  end
endmodule

// File: rtl/lpm_enable_dec.sv
module lpm_enable_dec
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pmode_e  mode_next,
  input  logic    dco_keep,
  output clk_en_t en_q
);
  clk_en_t en_d;

  assign en_d = mode_pattern(mode_next, dco_keep);

  always_ff @(posedge clk) begin
    if (rst) en_q <= EN_ALL_ON;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int CODE_W = MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [CODE_W-1:0] mode_wdata,
  input  logic              dco_drives_cpu,
  input  logic              irq,
  input  logic              reti,
  input  logic              saved_clr,
  output logic [CODE_W-1:0] cur_mode,
  output logic              in_service,
  output logic              cpu_clk_en,
  output logic              aux_clk_en,
  output logic              per_clk_en,
  output logic              dco_gen_en,
  output logic              xtal_en
);
  pmode_e  mode_q, mode_d;
  logic    srv_q;
  clk_en_t en_q;

  lpm_mode_seq #(.CODE_W(CODE_W)) i_seq (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .irq(irq), .reti(reti), .saved_clr(saved_clr),
    .mode_q(mode_q), .mode_d(mode_d), .srv_q(srv_q)
  );

  lpm_enable_dec i_dec (
    .clk(clk), .rst(rst), .mode_next(mode_d), .dco_keep(dco_drives_cpu), .en_q(en_q)
  );

  assign cur_mode   = CODE_W'(mode_q);
  assign in_service = srv_q;
  assign cpu_clk_en = en_q.cpu;
  assign aux_clk_en = en_q.aux;
  assign per_clk_en = en_q.per;
  assign dco_gen_en = en_q.dco;
  assign xtal_en    = en_q.xtal;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_wr,
  input logic [CODE_W-1:0] mode_wdata,
  input logic              dco_drives_cpu,
  input logic              irq,
  input logic              reti,
  input logic              saved_clr,
  input logic [CODE_W-1:0] cur_mode,
  input logic              in_service,
  input logic              cpu_clk_en,
  input logic              aux_clk_en,
  input logic              per_clk_en,
  input logic              dco_gen_en,
  input logic              xtal_en
);
  // R5
  wake_to_active_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_service && irq && cur_mode != '0) |=> (in_service && cur_mode == '0 && cpu_clk_en
      && aux_clk_en && per_clk_en && dco_gen_en && xtal_en));

  // R3
  service_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    in_service |-> (cpu_clk_en && aux_clk_en && per_clk_en && dco_gen_en && xtal_en));

  // R3
  cpu_only_active_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en == (cur_mode == '0));

  // R3
  xtal_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !xtal_en |-> (!aux_clk_en && !per_clk_en && !dco_gen_en && cur_mode == CODE_W'(5)));

  // R7
  return_leaves_chk: assert property (@(posedge clk) disable iff (rst)
    (in_service && reti) |=> !in_service);

  // R2
  illegal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_service && !(irq && cur_mode != '0) && mode_wr && int'(mode_wdata) > 5)
      |=> $stable(cur_mode));

  // R9
  write_in_service_chk: assert property (@(posedge clk) disable iff (rst)
    (in_service && !reti) |=> (in_service && cur_mode == '0));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.CODE_W(CODE_W)) i_chk (.*);

// File: tb/test_lpm_clk_ctrl.sv
module test_lpm_clk_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [2:0] mode_wdata = '0;
  logic       dco_drives_cpu = 1'b1;
  logic       irq = 1'b0;
  logic       reti = 1'b0;
  logic       saved_clr = 1'b0;
  logic [2:0] cur_mode;
  logic       in_service, cpu_clk_en, aux_clk_en, per_clk_en, dco_gen_en, xtal_en;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference state
  int m_mode = 0;
  int m_saved = 0;
  bit m_vld = 1'b0;
  bit m_srv = 1'b0;
  bit m_dco = 1'b1;

  always #4 clk = ~clk;

  lpm_clk_ctrl i_lpm_clk_ctrl (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .dco_drives_cpu(dco_drives_cpu), .irq(irq), .reti(reti), .saved_clr(saved_clr),
    .cur_mode(cur_mode), .in_service(in_service), .cpu_clk_en(cpu_clk_en),
    .aux_clk_en(aux_clk_en), .per_clk_en(per_clk_en), .dco_gen_en(dco_gen_en),
    .xtal_en(xtal_en)
  );

  function automatic logic [4:0] exp_en(int m, bit dco);
    logic [4:0] e; // cpu aux per dco xtal
    case (m)
      0: e = 5'b11111;
      1: e = 5'b01111;
      2: e = {3'b011, dco, 1'b1};
      3: e = 5'b01011;
      4: e = 5'b01001;
      default: e = 5'b00000;
    endcase
    return e;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " mode"}, int'(cur_mode), m_mode);
    chk({req, " service"}, int'(in_service), int'(m_srv));
    chk({req, " enables"}, int'({cpu_clk_en, aux_clk_en, per_clk_en, dco_gen_en, xtal_en}),
        int'(exp_en(m_mode, m_dco)));
  endtask

  // called at a falling edge; applies inputs for one cycle, updates the model
  task automatic step(bit wr, int wd, bit iq, bit rt, bit cl, bit dco);
    mode_wr = wr; mode_wdata = 3'(wd); irq = iq; reti = rt; saved_clr = cl;
    dco_drives_cpu = dco;
    if (m_srv) begin
      if (rt) begin
        m_mode = (m_vld && !cl) ? m_saved : 0;
        m_vld = 1'b0;
        m_srv = 1'b0;
      end else if (cl) m_vld = 1'b0;
    end else if (iq && m_mode != 0) begin
      m_saved = m_mode; m_vld = 1'b1; m_srv = 1'b1; m_mode = 0;
    end else if (wr && wd < 6) m_mode = wd;
    m_dco = dco;
    @(posedge clk);
    @(negedge clk);
    mode_wr = 1'b0; irq = 1'b0; reti = 1'b0; saved_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R2 / R3: every legal code, then illegal codes
    for (int c = 0; c < 6; c++) begin
      step(1, c, 0, 0, 0, 1);
      check_all("R3");
    end
    step(1, 3, 0, 0, 0, 1);
    step(1, 6, 0, 0, 0, 1);
    check_all("R2 illegal 6");
    step(1, 7, 0, 0, 0, 1);
    check_all("R2 illegal 7");

    // R4: level 1 with DCO used / not used
    step(1, 2, 0, 0, 0, 0);
    check_all("R4 dco off");
    step(0, 0, 0, 0, 0, 1);
    check_all("R4 dco on");

    // R5 / R7: wake from deepest level and restore
    step(1, 5, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1);
    check_all("R5 wake");
    step(1, 1, 1, 0, 0, 1);
    check_all("R9 write and irq in service");
    step(0, 0, 0, 1, 0, 1);
    check_all("R7 restore");

    // R6: irq in active
    step(1, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1);
    check_all("R6 irq active");

    // R8: clear then return; clear with return
    step(1, 4, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0, 1);
    check_all("R8 clear before return");
    step(1, 3, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 1, 1, 1);
    check_all("R8 clear with return");

    // R9: return and clear outside service
    step(1, 4, 0, 0, 0, 1);
    step(0, 0, 0, 1, 1, 1);
    check_all("R9 stray return");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, $urandom % 8, ($urandom % 5) == 0,
           ($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 4) != 0);
      check_all("R2 R3 R5 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule